// File: doc/BRIEF.md
# Video Timing to Stream Flag Generator

This block sits on the pixel-clock side of a parallel-video-to-stream bridge. It takes pixel data together with a data-enable, a vertical sync and a vertical blanking strobe, and turns the active pixels into write transactions for a FIFO. Each word written carries the pixel and two framing bits for a streaming video protocol. One bit marks the first pixel of a field (start of frame). The other marks the last pixel of each line (end of line).

All video inputs are registered first. The pixel path is then delayed by one further stage, so the falling edge of data-enable can be seen while the last active pixel is still waiting to be written. The start-of-frame flag is armed by a blanking flip-flop. That flip-flop is set when the OR of vertical sync and vertical blanking falls, and it is cleared by the next rising edge of data-enable. Every register advances only on cycles where the clock enable is high. A full FIFO causes the pixel to be dropped and raises a sticky overflow indication.

Top module: `vid_stream_flagger`

## Requirements
- R1: A pixel sampled on a clock-enabled edge appears on the write port in the cycle that follows the second clock-enabled edge, counting the sampling edge itself.
- R2: `fifo_wr_en` is high only in cycles where `ce` is high. `fifo_wr_data` does not change across an edge where `ce` is low.
- R3: Only pixels sampled with data-enable high are written. They are written in sampling order, each exactly once, with the pixel in bits [DATA_WIDTH-1:0] of the write word.
- R4: Bit DATA_WIDTH of the write word (end of line) is 1 exactly on the last pixel of a line, meaning a pixel whose next enabled sample has data-enable low.
- R5: Bit DATA_WIDTH+1 of the write word (start of frame) is 1 exactly on the first pixel after a falling edge of (vsync OR vblank). The data-enable rising edge must come at least one enabled sample after that falling edge. Later lines get no start-of-frame until another falling edge occurs.
- R6: A line that is one pixel long, when it is armed, carries both the start-of-frame and end-of-line bits on the same write.
- R7: After reset, no start-of-frame is produced until a falling edge of (vsync OR vblank) has been sampled.
- R8: While `fifo_full` is high, an active pixel due for writing is not written. It is dropped and `overflow` is set. `overflow` then stays high until reset.
- R9: Synchronous reset deasserts `fifo_wr_en`, clears `overflow` and clears the framing bits of the write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for all pipeline registers |
| vid_data | input | DATA_WIDTH | Pixel data |
| vid_de | input | 1 | Data enable, high on active pixels |
| vid_vsync | input | 1 | Vertical sync |
| vid_vblank | input | 1 | Vertical blanking |
| fifo_full | input | 1 | FIFO cannot accept a write |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | DATA_WIDTH+2 | {sof, eol, pixel} |
| overflow | output | 1 | Sticky flag: a pixel was dropped on full |

## Verification
Complete small frames are driven with the vertical interval signalled once by vblank and once by vsync alone, which shows that either source arms the start-of-frame flag. The same frames are then repeated with a gapped clock enable, which separates clock-enabled sampling from raw clock counting. Frames of one-pixel lines, frames that follow with no blanking interval, and a frame sent right after reset expose whether the arming flip-flop is set and cleared only on the right edges. A frame sent into a permanently full FIFO, followed by reset, checks dropping and the stickiness of the overflow flag. One isolated pixel measures the pipeline latency exactly.

// File: rtl/vid_stream_pkg.sv
package vid_stream_pkg;
  typedef struct packed {
    logic sof;
    logic eol;
  } vs_flags_t;
endpackage

// File: rtl/vs_input_reg.sv
module vs_input_reg #(
  parameter int DATA_WIDTH = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [DATA_WIDTH-1:0] data_i,
  input  logic                  de_i,
  input  logic                  vsync_i,
  input  logic                  vblank_i,
  output logic [DATA_WIDTH-1:0] data_o,
  output logic                  de_o,
  output logic                  blank_o
);
  logic vsync_q, vblank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o   <= '0;
      de_o     <= 1'b0;
      vsync_q  <= 1'b0;
      vblank_q <= 1'b0;
    end else if (ce) begin
      data_o   <= data_i;
      de_o     <= de_i;
      vsync_q  <= vsync_i;
      vblank_q <= vblank_i;
    end
  end

  assign blank_o = vsync_q | vblank_q;
endmodule

// File: rtl/vs_flag_gen.sv
module vs_flag_gen
  import vid_stream_pkg::*;
#(
  parameter int DATA_WIDTH = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [DATA_WIDTH-1:0] data_s1,
  input  logic                  de_s1,
  input  logic                  blank_s1,
  output logic [DATA_WIDTH-1:0] data_s2,
  output logic                  de_s2,
  output vs_flags_t             flags_s2
);
  logic blank_s2;
  logic armed;
  logic sof_s2;
  logic de_rise;
  logic blank_fall;

  assign de_rise    = de_s1 & ~de_s2;
  assign blank_fall = blank_s2 & ~blank_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_s2  <= '0;
      de_s2    <= 1'b0;
      blank_s2 <= 1'b0;
      armed    <= 1'b0;
      sof_s2   <= 1'b0;
    end else if (ce) begin
      data_s2  <= data_s1;
      de_s2    <= de_s1;
      blank_s2 <= blank_s1;
      sof_s2   <= de_rise & armed;
      if (blank_fall)   armed <= 1'b1;
      else if (de_rise) armed <= 1'b0;
    end
  end

  always_comb begin
    flags_s2.sof = sof_s2 & de_s2;
    flags_s2.eol = de_s2 & ~de_s1;
  end
endmodule

// File: rtl/vs_fifo_write.sv
module vs_fifo_write
  import vid_stream_pkg::*;
#(
  parameter int DATA_WIDTH = 24,
  localparam int WORD_W = DATA_WIDTH + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [DATA_WIDTH-1:0] data_s2,
  input  logic                  de_s2,
  input  vs_flags_t             flags_s2,
  input  logic                  fifo_full,
  output logic                  wr_en,
  output logic [WORD_W-1:0]     wr_data,
  output logic                  overflow
);
  logic due;

  assign due     = ce & de_s2;
  assign wr_en   = due & ~fifo_full;
  assign wr_data = {flags_s2.sof, flags_s2.eol, data_s2};

  always_ff @(posedge clk) begin
    if (rst)                  overflow <= 1'b0;
    else if (due & fifo_full) overflow <= 1'b1;
  end
endmodule

// File: rtl/vid_stream_flagger.sv
module vid_stream_flagger
  import vid_stream_pkg::*;
#(
  parameter int DATA_WIDTH = 24,
  localparam int WORD_W = DATA_WIDTH + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [DATA_WIDTH-1:0] vid_data,
  input  logic                  vid_de,
  input  logic                  vid_vsync,
  input  logic                  vid_vblank,
  input  logic                  fifo_full,
  output logic                  fifo_wr_en,
  output logic [WORD_W-1:0]     fifo_wr_data,
  output logic                  overflow
);
  logic [DATA_WIDTH-1:0] data_s1, data_s2;
  logic                  de_s1, de_s2, blank_s1;
  vs_flags_t             flags_s2;

  vs_input_reg #(.DATA_WIDTH(DATA_WIDTH)) u_in (
    .clk(clk), .rst(rst), .ce(ce),
    .data_i(vid_data), .de_i(vid_de), .vsync_i(vid_vsync), .vblank_i(vid_vblank),
    .data_o(data_s1), .de_o(de_s1), .blank_o(blank_s1)
  );

  vs_flag_gen #(.DATA_WIDTH(DATA_WIDTH)) u_flags (
    .clk(clk), .rst(rst), .ce(ce),
    .data_s1(data_s1), .de_s1(de_s1), .blank_s1(blank_s1),
    .data_s2(data_s2), .de_s2(de_s2), .flags_s2(flags_s2)
  );

  vs_fifo_write #(.DATA_WIDTH(DATA_WIDTH)) u_wr (
    .clk(clk), .rst(rst), .ce(ce),
    .data_s2(data_s2), .de_s2(de_s2), .flags_s2(flags_s2),
    .fifo_full(fifo_full),
    .wr_en(fifo_wr_en), .wr_data(fifo_wr_data), .overflow(overflow)
  );
endmodule

// File: rtl/vid_stream_flagger_chk.sv
module vid_stream_flagger_chk #(
  parameter int DATA_WIDTH = 24
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ce,
  input logic                  fifo_full,
  input logic                  fifo_wr_en,
  input logic [DATA_WIDTH+1:0] fifo_wr_data,
  input logic                  overflow
);
  a_r2_write_needs_ce: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> ce);

  a_r2_data_held_without_ce: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(fifo_wr_data));

  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_wr_en);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r8_overflow_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(fifo_full));
endmodule

bind vid_stream_flagger vid_stream_flagger_chk #(.DATA_WIDTH(DATA_WIDTH)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .fifo_full(fifo_full),
  .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .overflow(overflow)
);

// File: tb/tb_vid_stream_flagger.sv
module tb_vid_stream_flagger;
  localparam int DW = 24;
  localparam int WW = DW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic [DW-1:0] vid_data = '0;
  logic vid_de = 1'b0, vid_vsync = 1'b0, vid_vblank = 1'b0, fifo_full = 1'b0;
  logic fifo_wr_en, overflow;
  logic [WW-1:0] fifo_wr_data;

  vid_stream_flagger #(.DATA_WIDTH(DW)) dut (
    .clk(clk), .rst(rst), .ce(ce), .vid_data(vid_data), .vid_de(vid_de),
    .vid_vsync(vid_vsync), .vid_vblank(vid_vblank), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data), .overflow(overflow)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [WW-1:0] exp_q[$];
  bit mon_on = 0, model_on = 0;
  bit m_prev_de = 0, m_prev_blank = 0, m_armed = 0;
  int n_writes = 0, n_sof = 0, n_both = 0;
  logic [DW-1:0] pix = 24'h000100;

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input bit de, input bit vs, input bit vb, input logic [DW-1:0] d,
                      input bit c, input bit full);
    logic [WW-1:0] e;
    @(negedge clk);
    vid_de = de; vid_vsync = vs; vid_vblank = vb; vid_data = d; ce = c; fifo_full = full;
    if (c && model_on) begin
      if (m_prev_blank && !(vs | vb)) m_armed = 1;
      if (m_prev_de && !de && exp_q.size() > 0) exp_q[exp_q.size()-1][DW] = 1'b1;
      if (de) begin
        e = {1'b0, 1'b0, d};
        if (!m_prev_de) begin
          e[DW+1] = m_armed;
          m_armed = 0;
        end
        exp_q.push_back(e);
      end
      m_prev_blank = vs | vb;
      m_prev_de = de;
    end
    #1;
    if (mon_on) begin
      if (!c) chk(fifo_wr_en == 1'b0, "R2 write without ce", {25'b0, fifo_wr_en}, '0);
      if (fifo_wr_en) begin
        n_writes++;
        if (fifo_wr_data[DW+1]) n_sof++;
        if (fifo_wr_data[DW+1] && fifo_wr_data[DW]) n_both++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected write", fifo_wr_data, '0);
        end else begin
          e = exp_q.pop_front();
          chk(fifo_wr_data[DW-1:0] == e[DW-1:0], "R3 pixel order", fifo_wr_data, e);
          chk(fifo_wr_data[DW] == e[DW], "R4 eol bit", fifo_wr_data, e);
          chk(fifo_wr_data[DW+1] == e[DW+1], "R5 sof bit", fifo_wr_data, e);
        end
      end
    end
  endtask

  function automatic bit ce_of(input int mode, input int i);
    return (mode == 0) ? 1'b1 : ((i % 3) != 2);
  endfunction

  task automatic frame(input int lines, input int ppl, input int hb, input int vb_len,
                       input bit use_vs, input int ce_mode, input bit full);
    int k = 0;
    for (int i = 0; i < vb_len; i++) begin
      step(0, use_vs, !use_vs, '0, ce_of(ce_mode, k), full); k++;
    end
    for (int i = 0; i < hb; i++) begin
      step(0, 0, 0, '0, ce_of(ce_mode, k), full); k++;
    end
    for (int l = 0; l < lines; l++) begin
      for (int p = 0; p < ppl; p++) begin
        step(1, 0, 0, pix, ce_of(ce_mode, k), full); k++; pix++;
      end
      for (int i = 0; i < hb; i++) begin
        step(0, 0, 0, '0, ce_of(ce_mode, k), full); k++;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ce = 1; vid_de = 0; vid_vsync = 0; vid_vblank = 0; fifo_full = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_q.delete();
    m_prev_de = 0; m_prev_blank = 0; m_armed = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(0, 0, 0, '0, 1, 0);
    chk(exp_q.size() == 0, "R3 all pixels written", WW'(exp_q.size()), '0);
  endtask

  initial begin
    do_reset();
    #1;
    chk(fifo_wr_en == 0, "R9 wr_en after reset", {25'b0, fifo_wr_en}, '0);
    chk(overflow == 0, "R9 overflow after reset", {25'b0, overflow}, '0);
    chk(fifo_wr_data[DW+1:DW] == 2'b00, "R9 flags after reset", fifo_wr_data, '0);

    // R1 latency with a single isolated pixel
    step(1, 0, 0, 24'hABCDEF, 1, 0);
    chk(fifo_wr_en == 0, "R1 no write at sampling", {25'b0, fifo_wr_en}, '0);
    step(0, 0, 0, '0, 1, 0);
    chk(fifo_wr_en == 0, "R1 no write after one edge", {25'b0, fifo_wr_en}, '0);
    step(0, 0, 0, '0, 1, 0);
    chk(fifo_wr_en == 1 && fifo_wr_data == {2'b01, 24'hABCDEF}, "R1 R7 write after two edges",
        fifo_wr_data, {2'b01, 24'hABCDEF});
    step(0, 0, 0, '0, 1, 0);

    // R7: frame straight after reset without blanking edge
    do_reset();
    mon_on = 1; model_on = 1; n_sof = 0;
    frame(3, 4, 3, 0, 0, 0, 0);
    drain();
    chk(n_sof == 0, "R7 no sof before blank edge", WW'(n_sof), '0);

    // R5 with vblank, then vsync, then gapped ce
    n_sof = 0;
    frame(3, 5, 3, 4, 0, 0, 0);
    frame(2, 4, 3, 2, 1, 0, 0);
    frame(3, 6, 4, 3, 0, 1, 0);
    drain();
    chk(n_sof == 3, "R5 one sof per field", WW'(n_sof), WW'(3));

    // R5: lines without new blanking get no sof
    n_sof = 0;
    frame(4, 3, 2, 0, 0, 0, 0);
    drain();
    chk(n_sof == 0, "R5 no sof without blank edge", WW'(n_sof), '0);

    // R6: one-pixel lines
    n_both = 0;
    frame(4, 1, 2, 2, 0, 0, 0);
    frame(3, 1, 3, 2, 1, 1, 0);
    drain();
    chk(n_both == 2, "R6 sof and eol together", WW'(n_both), WW'(2));

    // R8: full FIFO drops pixels and sets sticky overflow
    mon_on = 0; model_on = 0; n_writes = 0;
    fork
      frame(2, 4, 3, 2, 0, 0, 1);
      begin
        while (fifo_full !== 1'b1) @(negedge clk);
        while (fifo_full === 1'b1) begin
          #2; if (fifo_wr_en) n_writes++;
          @(negedge clk);
        end
      end
    join_any
    step(0, 0, 0, '0, 1, 1);
    chk(n_writes == 0, "R8 no write while full", WW'(n_writes), '0);
    chk(overflow == 1, "R8 overflow set", {25'b0, overflow}, WW'(1));
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0, 1, 0);
    chk(overflow == 1, "R8 overflow sticky", {25'b0, overflow}, WW'(1));
    do_reset();
    #1;
    chk(overflow == 0, "R8 R9 overflow cleared by reset", {25'b0, overflow}, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule